// File: doc/BRIEF.md
# Watchdog and Power-On Reset Supervisor

This block drives a system reset from three causes: the power-on reset input, a supply-good flag from an external comparator, and a watchdog timer. A loss of supply-good, or power-on, holds the reset active. After the supply is back, the reset stays active for a fixed number of clock cycles set by a parameter, and only then releases.

The watchdog watches a shared select/kick line. Each high-to-low transition of that line restarts the count. If no such transition arrives within the selected timeout, the block fires a reset of the same fixed length, and the count then starts again from zero. A line stuck high or stuck low therefore times out. A two-bit select chooses one of three timeouts, each set by a parameter, or switches the watchdog off. A separate enable input also switches it off.

The kick line is asynchronous and passes through a synchroniser before the block looks for edges. Both an active-high and an active-low reset leave the block, each from its own register.

Top module: `rst_supervisor`

## Requirements
- R1: While `rst` is high, `rst_o` is 1 and `rst_n_o` is 0. After `rst` falls with `pwr_good_i` high, `rst_o` stays 1 for exactly HOLD_CYC rising clock edges, counted from the first edge that samples `rst` low.
- R2: One edge after `pwr_good_i` is sampled low, `rst_o` is 1. It stays 1 for as long as `pwr_good_i` stays low, and kicks have no effect during that time.
- R3: After `pwr_good_i` returns high, `rst_o` falls after exactly HOLD_CYC edges that sample it high.
- R4: With the watchdog enabled, `rst_o` rises exactly T edges after a release if no kick arrives. This holds whether `cs_kick_i` is held high or held low.
- R5: A high-to-low transition of `cs_kick_i` clears the watchdog count on the third rising edge after the low level is set up. The next timeout therefore comes T+3 edges after the kick is driven. Kicks spaced closer than T keep `rst_o` low.
- R6: `tmo_sel_i` encodes the timeout T as follows: 2'b00 gives TMO_SHORT, 2'b01 gives TMO_MID, 2'b10 gives TMO_LONG, and 2'b11 disables the watchdog.
- R7: With `wd_en_i` low, the watchdog never asserts reset and its count stays cleared. Once `wd_en_i` returns high, the timeout takes T edges.
- R8: A watchdog reset lasts exactly HOLD_CYC edges, and the next timeout is again a full T edges.
- R9: `rst_n_o` is always the complement of `rst_o`.
- R10: The watchdog count does not advance while reset is active. After a supply-loss period longer than any timeout, the first timeout still takes a full T edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| pwr_good_i | input | 1 | Supply-good flag, already synchronous |
| cs_kick_i | input | 1 | Asynchronous select/kick line; a falling edge restarts the watchdog |
| wd_en_i | input | 1 | Watchdog enable |
| tmo_sel_i | input | 2 | Timeout select (00 short, 01 mid, 10 long, 11 off) |
| rst_o | output | 1 | Active-high system reset, registered |
| rst_n_o | output | 1 | Active-low system reset, registered |

## Verification
The bench targets the kick line held low. A design that detected levels instead of falling edges would never time out in that state. It also checks the exact hold length after supply return and after a bite, where an off-by-one counter shortens or stretches the reset by a cycle. A long supply loss followed by a full-length timeout exposes a counter that runs during reset: such a design would bite early, or at once, after release. The bench also changes the timeout select and enable mid-count. Random stimulus then compares every cycle against a bench model, which catches edge detection on the raw, unsynchronised line, because that shifts the restart by two cycles.

// File: rtl/supv_pkg.sv
package supv_pkg;
  typedef enum logic [1:0] {
    TMO_SHORT = 2'b00,
    TMO_MID   = 2'b01,
    TMO_LONG  = 2'b10,
    TMO_OFF   = 2'b11
  } tmo_sel_e;
endpackage

// File: rtl/supv_kick_sync.sv
module supv_kick_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic fall_o
);
  logic [STAGES-1:0] sr_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= line_i;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sr_q <= '1;
        else     sr_q <= {sr_q[STAGES-2:0], line_i};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sr_q[STAGES-1];
  end

  assign fall_o = prev_q & ~sr_q[STAGES-1];
endmodule

// File: rtl/supv_wd_timer.sv
module supv_wd_timer
  import supv_pkg::*;
#(
  parameter int TMO_SHORT_CYC = 16,
  parameter int TMO_MID_CYC   = 32,
  parameter int TMO_LONG_CYC  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       hold_i,
  input  logic       kick_i,
  input  logic       wd_en_i,
  input  logic [1:0] tmo_sel_i,
  output logic       bite_o
);
  localparam int CW = $clog2(TMO_LONG_CYC + 1);
  localparam logic [CW-1:0] LIM_S = CW'(TMO_SHORT_CYC - 1);
  localparam logic [CW-1:0] LIM_M = CW'(TMO_MID_CYC - 1);
  localparam logic [CW-1:0] LIM_L = CW'(TMO_LONG_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;
  logic          armed;

  always_comb begin
    lim   = LIM_S;
    armed = wd_en_i;
    case (tmo_sel_e'(tmo_sel_i))
      TMO_SHORT: lim = LIM_S;
      TMO_MID:   lim = LIM_M;
      TMO_LONG:  lim = LIM_L;
      default:   armed = 1'b0;
    endcase
  end

  assign bite_o = armed & ~hold_i & (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst || hold_i || !armed || kick_i) cnt_q <= '0;
    else if (!bite_o)                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/supv_hold_gen.sv
module supv_hold_gen #(
  parameter int HOLD_CYC = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_good_i,
  input  logic bite_i,
  output logic active_o,
  output logic rst_n_o
);
  localparam int HW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [HW-1:0] LAST = HW'(HOLD_CYC - 1);

  logic          act_q, act_d;
  logic [HW-1:0] cnt_q, cnt_d;
  logic          rstn_q;

  always_comb begin
    act_d = act_q;
    cnt_d = cnt_q;
    if (!pwr_good_i || bite_i) begin
      act_d = 1'b1;
      cnt_d = '0;
    end else if (act_q) begin
      if (cnt_q == LAST) begin
        act_d = 1'b0;
        cnt_d = '0;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q  <= 1'b1;
      cnt_q  <= '0;
      rstn_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      cnt_q  <= cnt_d;
      rstn_q <= ~act_d;
    end
  end

  assign active_o = act_q;
  assign rst_n_o  = rstn_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_CYC      = 20_000_000,
  parameter int TMO_SHORT_CYC = 15_000_000,
  parameter int TMO_MID_CYC   = 60_000_000,
  parameter int TMO_LONG_CYC  = 140_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pwr_good_i,
  input  logic       cs_kick_i,
  input  logic       wd_en_i,
  input  logic [1:0] tmo_sel_i,
  output logic       rst_o,
  output logic       rst_n_o
);
  logic kick;
  logic bite;
  logic active;

  supv_kick_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst    (rst),
    .line_i (cs_kick_i),
    .fall_o (kick)
  );

  supv_wd_timer #(
    .TMO_SHORT_CYC (TMO_SHORT_CYC),
    .TMO_MID_CYC   (TMO_MID_CYC),
    .TMO_LONG_CYC  (TMO_LONG_CYC)
  ) u_wd (
    .clk       (clk),
    .rst       (rst),
    .hold_i    (active),
    .kick_i    (kick),
    .wd_en_i   (wd_en_i),
    .tmo_sel_i (tmo_sel_i),
    .bite_o    (bite)
  );

  supv_hold_gen #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk        (clk),
    .rst        (rst),
    .pwr_good_i (pwr_good_i),
    .bite_i     (bite),
    .active_o   (active),
    .rst_n_o    (rst_n_o)
  );

  assign rst_o = active;
endmodule

// File: rtl/supv_checker.sv
module supv_checker #(
  parameter int HOLD_CYC = 16
) (
  input logic       clk,
  input logic       rst,
  input logic       pwr_good_i,
  input logic       wd_en_i,
  input logic [1:0] tmo_sel_i,
  input logic       rst_o,
  input logic       rst_n_o
);
  localparam int HW = $clog2(HOLD_CYC + 1);
  localparam logic [HW-1:0] HMAX = HW'(HOLD_CYC);

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (rst || !rst_o)     hi_cnt <= '0;
    else if (hi_cnt != HMAX) hi_cnt <= hi_cnt + 1'b1;
  end

  AST_OUT_COMPLEMENT: assert property (@(posedge clk) disable iff (rst)
    rst_o != rst_n_o); // R9

  AST_PG_LOW_RESET: assert property (@(posedge clk) disable iff (rst)
    !pwr_good_i |=> rst_o); // R2

  AST_RELEASE_NEEDS_PG: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> $past(pwr_good_i)); // R3

  AST_HOLD_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(rst_o) |-> hi_cnt >= HMAX); // R8

  AST_BITE_WHEN_ARMED: assert property (@(posedge clk) disable iff (rst)
    ($rose(rst_o) && $past(pwr_good_i)) |-> ($past(wd_en_i) && $past(tmo_sel_i) != 2'b11)); // R6
endmodule

bind rst_supervisor supv_checker #(.HOLD_CYC(HOLD_CYC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .pwr_good_i (pwr_good_i),
  .wd_en_i    (wd_en_i),
  .tmo_sel_i  (tmo_sel_i),
  .rst_o      (rst_o),
  .rst_n_o    (rst_n_o)
);

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
  localparam int HOLD = 12;
  localparam int T0   = 20;
  localparam int T1   = 45;
  localparam int T2   = 90;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwr_good_i = 1'b1;
  logic       cs_kick_i = 1'b1;
  logic       wd_en_i = 1'b1;
  logic [1:0] tmo_sel_i = 2'b00;
  logic       rst_o, rst_n_o;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit cmp_on = 1'b0;

  always #5 clk = ~clk;

  rst_supervisor #(
    .HOLD_CYC(HOLD), .TMO_SHORT_CYC(T0), .TMO_MID_CYC(T1), .TMO_LONG_CYC(T2)
  ) u_dut (
    .clk(clk), .rst(rst), .pwr_good_i(pwr_good_i), .cs_kick_i(cs_kick_i),
    .wd_en_i(wd_en_i), .tmo_sel_i(tmo_sel_i), .rst_o(rst_o), .rst_n_o(rst_n_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int tmo_of(input logic [1:0] s);
    case (s)
      2'b00:   return T0;
      2'b01:   return T1;
      2'b10:   return T2;
      default: return 0;
    endcase
  endfunction

  // bench model built from the requirements
  logic m_s1 = 1, m_s2 = 1, m_s3 = 1, m_act = 1;
  int   m_hc = 0, m_wc = 0;
  always @(posedge clk) begin
    logic fall, en, bite, act_old;
    int t;
    fall = m_s3 & ~m_s2;
    t = tmo_of(tmo_sel_i);
    en = wd_en_i && (tmo_sel_i != 2'b11);
    bite = en && !m_act && (m_wc >= t - 1);
    act_old = m_act;
    if (rst) begin
      m_act = 1; m_hc = 0; m_wc = 0; m_s1 = 1; m_s2 = 1; m_s3 = 1;
    end else begin
      if (!pwr_good_i || bite) begin m_act = 1; m_hc = 0; end
      else if (m_act) begin
        if (m_hc == HOLD - 1) begin m_act = 0; m_hc = 0; end
        else m_hc++;
      end
      if (act_old || !en || fall) m_wc = 0;
      else if (!bite) m_wc++;
      m_s3 = m_s2; m_s2 = m_s1; m_s1 = cs_kick_i;
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      chk(rst_o === m_act, "R4/R5 model rst_o", int'(rst_o), int'(m_act));
      chk(rst_n_o === ~rst_o, "R9 complement", int'(rst_n_o), int'(~rst_o));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic cnt_until(input logic val, output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (rst_o !== val && n < 1000);
  endtask

  initial begin
    int n;
    bit seen;
    void'($urandom(32'd4321));
    repeat (5) @(negedge clk);
    chk(rst_o === 1'b1, "R1 reset state rst_o", int'(rst_o), 1);
    chk(rst_n_o === 1'b0, "R1 reset state rst_n_o", int'(rst_n_o), 0);
    rst = 0;
    cnt_until(1'b0, n); chk(n == HOLD, "R1 power-on hold", n, HOLD);
    cnt_until(1'b1, n); chk(n == T0, "R4 timeout line high", n, T0);
    cnt_until(1'b0, n); chk(n == HOLD, "R8 bite hold", n, HOLD);
    cnt_until(1'b1, n); chk(n == T0, "R8 restart from zero", n, T0);
    cs_kick_i = 0;
    cnt_until(1'b0, n); chk(n == HOLD, "R8 bite hold 2", n, HOLD);
    cnt_until(1'b1, n); chk(n == T0, "R4 timeout line low", n, T0);
    tmo_sel_i = 2'b01;
    cnt_until(1'b0, n); chk(n == HOLD, "R8 hold", n, HOLD);
    cnt_until(1'b1, n); chk(n == T1, "R6 mid timeout", n, T1);
    tmo_sel_i = 2'b10;
    cnt_until(1'b0, n);
    cnt_until(1'b1, n); chk(n == T2, "R6 long timeout", n, T2);
    tmo_sel_i = 2'b11;
    cnt_until(1'b0, n);
    seen = 0;
    repeat (300) begin @(negedge clk); if (rst_o) seen = 1; end
    chk(!seen, "R6 select 11 disables", int'(seen), 0);
    wd_en_i = 0; tmo_sel_i = 2'b00;
    seen = 0;
    repeat (300) begin @(negedge clk); if (rst_o) seen = 1; end
    chk(!seen, "R7 enable low disables", int'(seen), 0);
    wd_en_i = 1;
    cnt_until(1'b1, n); chk(n == T0, "R7 re-enable full timeout", n, T0);
    cnt_until(1'b0, n);
    seen = 0;
    for (int i = 0; i < 20; i++) begin
      cs_kick_i = 1; repeat (5) begin @(negedge clk); if (rst_o) seen = 1; end
      cs_kick_i = 0; repeat (5) begin @(negedge clk); if (rst_o) seen = 1; end
    end
    chk(!seen, "R5 periodic kicks hold off reset", int'(seen), 0);
    cs_kick_i = 1; repeat (5) @(negedge clk);
    cs_kick_i = 0;
    cnt_until(1'b1, n); chk(n == T0 + 3, "R5 kick latency", n, T0 + 3);
    cnt_until(1'b0, n);
    repeat (5) @(negedge clk);
    pwr_good_i = 0;
    @(posedge clk); @(negedge clk);
    chk(rst_o === 1'b1, "R2 supply loss", int'(rst_o), 1);
    seen = 0;
    repeat (150) begin
      cs_kick_i = ~cs_kick_i;
      @(negedge clk); if (!rst_o) seen = 1;
    end
    chk(!seen, "R2 held during loss", int'(seen), 0);
    cs_kick_i = 0;
    pwr_good_i = 1;
    cnt_until(1'b0, n); chk(n == HOLD, "R3 hold after supply return", n, HOLD);
    cnt_until(1'b1, n); chk(n == T0, "R10 count frozen in reset", n, T0);

    rst = 1; repeat (3) @(negedge clk);
    rst = 0; cmp_on = 1;
    for (int k = 0; k < 4000; k++) begin
      if (pwr_good_i == 0) begin
        if ($urandom_range(0, 9) == 0) pwr_good_i = 1;
      end else if ($urandom_range(0, 199) == 0) pwr_good_i = 0;
      if ($urandom_range(0, 11) == 0) cs_kick_i = ~cs_kick_i;
      if ($urandom_range(0, 299) == 0) wd_en_i = ~wd_en_i;
      if ($urandom_range(0, 149) == 0) tmo_sel_i = 2'($urandom_range(0, 3));
      @(negedge clk);
    end
    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule